// File: doc/BRIEF.md
# RTC Link Bus Front End

This block sits on a 32-bit memory-mapped bus and gives software two ways to reach the always-on clock domain. Software can drive the three wires of a slow serial link one at a time: a clock, an enable and a data line toward the link. It reads back the link's return data and its ready flag. The block also holds a one-shot shifter. It sends a 16-bit configuration word to the analog section with a clock that the shifter generates itself, so software does not have to toggle that word out by hand.

The configuration word comes from two places. Its upper byte is held in a word of its own. Its lower byte is written in the same word as the start command. While the shifter runs, a busy flag is set and the manual link wires are frozen. Software starts a transfer and then polls the busy flag until it falls. The host side sets its own limit on how long it waits, on the order of ten milliseconds.

Top module: `rtc_link_frontend`

## Requirements
- R1: After reset the link wires, the shifter clock and the shifter data are low, busy reads 0, and the two spare words read 0. The configuration reset value is 0x180A, which gives a bias field of 5 in bits 3:1 and a voltage field of 3 in bits 12:11. Word 0x10 therefore reads 0x18, and control bits 31:24 read 0x0A.
- R2: A write to the control word at 0x00 drives the link wires from the next cycle onward: clock from bit 0, enable from bit 1, data from bit 2. Reading the control word returns those bits in the same positions.
- R3: The status word at 0x04 reads the link return data in bit 0 and the ready flag in bit 1, both taken through a two-stage synchronizer, so they appear two clocks after the inputs change. All other bits of the status word read 0.
- R4: The words at 0x08 and 0x0C are 32-bit read/write storage. The word at 0x10 stores and returns only bits 7:0, the upper configuration byte; its other bits read 0.
- R5: Writing 0x00 with bit 17 set while the shifter is idle latches the payload {word 0x10 bits 7:0, write data bits 31:24}. Busy (control bit 22) then reads 1 for exactly 64 cycles, that is 32 × HALF_CYC, starting the cycle after the write. Bit 17 always reads 0.
- R6: The shifter sends the payload MSB first. Each bit is held on the shifter data line for 4 cycles, and the shifter clock is low for the first 2 of them and high for the last 2. While idle, both lines are low.
- R7: While busy, a control write does not change the link wires and does not restart the shifter. It does update bits 31:24, and a write to 0x10 made then does not alter the word being sent.
- R8: Offsets 0x14 to 0x1C read 0. Writes to those offsets, and to the status word, change nothing.
- R9: Byte enables are ignored, so every write updates the full word even when all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address; bits 1:0 are not decoded |
| bus_wdata | input | 32 | Write data |
| bus_byte_en | input | 4 | Byte enables, ignored |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| link_sclk | output | 1 | Manual link clock |
| link_sen | output | 1 | Manual link enable |
| link_sdi | output | 1 | Manual link data toward the link |
| link_sdo | input | 1 | Link return data |
| link_rdy | input | 1 | Link ready flag |
| cfg_clk | output | 1 | Shifter-generated clock |
| cfg_dat | output | 1 | Shifter data, MSB first |

## Verification
A shifter counter that is off by one shows up at once as a cfg_clk edge in the wrong cycle. It also shows up as busy falling one cycle early or late on the bus read of bit 22. A wrong bit index shows up as a wrong cfg_dat value within four cycles of the start. A wrongly gated write enable shows up in the link wires, or in a readback word, on the cycle after the offending write. A missing or extra synchronizer stage shifts status bits 0 and 1 by a cycle. The reference model is compared with every port on every clock, so each of these faults is caught within a few cycles of the stimulus that exposes it.

// File: rtl/rtcfe_pkg.sv
package rtcfe_pkg;
   // word indices within the decoded window (byte offset / 4)
   localparam int WORD_CTRL   = 0;
   localparam int WORD_STAT   = 1;
   localparam int WORD_SPARE0 = 2;
   localparam int WORD_HI     = 4;

   // control word fields
   localparam int BIT_START = 17;
   localparam int BIT_BUSY  = 22;
   localparam int LO_LSB    = 24;
   localparam int BYTE_W    = 8;
   localparam int CFG_W     = 2 * BYTE_W;

   // sclk lands in bit 0, sen in bit 1, sdi in bit 2
   typedef struct packed {
      logic sdi;
      logic sen;
      logic sclk;
   } line_t;

   function automatic logic [31:0] ctrl_word(input logic [BYTE_W-1:0] lo,
                                             input logic busy,
                                             input line_t lines);
      logic [31:0] w;
      w = '0;
      w[LO_LSB +: BYTE_W] = lo;
      w[BIT_BUSY]         = busy;
      w[2:0]              = lines;
      return w;
   endfunction
endpackage

// File: rtl/rtcfe_sync.sv
module rtcfe_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("rtcfe_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign q_o = d_i;
   end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[0] <= '0;
         else        stage_q[0] <= d_i;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
      assign q_o = stage_q[STAGES-1];
   end
endmodule

// File: rtl/rtcfe_cfg_shifter.sv
module rtcfe_cfg_shifter #(
   parameter int HALF_CYC = 2,
   parameter int CFG_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CFG_W-1:0] payload_i,
   output logic             busy_o,
   output logic             ser_clk_o,
   output logic             ser_dat_o
);
   localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam int BIT_W = (CFG_W > 1) ? $clog2(CFG_W) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CFG_W - 1);

   if (HALF_CYC < 1) begin : g_bad_half
      $error("rtcfe_cfg_shifter: HALF_CYC must be at least 1");
   end
   if (CFG_W < 2 || (1 << BIT_W) != CFG_W) begin : g_bad_width
      $error("rtcfe_cfg_shifter: CFG_W must be a power of two >= 2");
   end

   logic             busy_q;
   logic             phase_q;
   logic [DIV_W-1:0] div_q;
   logic [BIT_W-1:0] bit_q;
   logic [CFG_W-1:0] shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         div_q   <= '0;
         bit_q   <= '0;
         shreg_q <= '0;
      end else if (start_i && !busy_q) begin
         busy_q  <= 1'b1;
         phase_q <= 1'b0;
         div_q   <= '0;
         bit_q   <= '0;
         shreg_q <= payload_i;
      end else if (busy_q) begin
         if (div_q == DIV_LAST) begin
            div_q   <= '0;
            phase_q <= ~phase_q;
            if (phase_q) begin
               shreg_q <= {shreg_q[CFG_W-2:0], 1'b0};
               bit_q   <= bit_q + 1'b1;
               if (bit_q == BIT_LAST) busy_q <= 1'b0;
            end
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

   assign busy_o    = busy_q;
   assign ser_clk_o = phase_q;
   assign ser_dat_o = shreg_q[CFG_W-1];
endmodule

// File: rtl/rtcfe_regfile.sv
module rtcfe_regfile
   import rtcfe_pkg::*;
#(
   parameter int          ADDR_W    = 5,
   parameter int          BUS_W     = 32,
   parameter int          NUM_SPARE = 2,
   parameter logic [15:0] CFG_RESET = 16'h180A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   input  logic              busy_i,
   input  logic [1:0]        stat_i,
   output line_t             lines_o,
   output logic              start_o,
   output logic [CFG_W-1:0]  payload_o,
   output logic [BUS_W-1:0]  rdata_o
);
   localparam int IDX_W = ADDR_W - 2;

   if (BUS_W != 32) begin : g_bad_bus
      $error("rtcfe_regfile: BUS_W must be 32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("rtcfe_regfile: ADDR_W must be at least 5");
   end
   if (NUM_SPARE < 1 || NUM_SPARE > 2) begin : g_bad_spare
      $error("rtcfe_regfile: NUM_SPARE must be 1 or 2");
   end

   logic [IDX_W-1:0]  idx;
   logic              ctrl_wr;
   logic              unused_lsb;
   line_t             lines_q;
   logic [BYTE_W-1:0] lo_q;
   logic [BYTE_W-1:0] hi_q;
   logic [BUS_W-1:0]  spare_q [NUM_SPARE];

   assign idx        = addr_i[ADDR_W-1:2];
   assign unused_lsb = ^addr_i[1:0];
   assign ctrl_wr    = wr_en_i && (idx == IDX_W'(WORD_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lines_q <= '0;
         lo_q    <= CFG_RESET[BYTE_W-1:0];
      end else if (ctrl_wr) begin
         lo_q <= wdata_i[LO_LSB +: BYTE_W];
         if (!busy_i) lines_q <= wdata_i[2:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_q <= CFG_RESET[CFG_W-1:BYTE_W];
      else if (wr_en_i && idx == IDX_W'(WORD_HI))
         hi_q <= wdata_i[BYTE_W-1:0];
   end

   for (genvar i = 0; i < NUM_SPARE; i++) begin : g_spare
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            spare_q[i] <= '0;
         else if (wr_en_i && idx == IDX_W'(WORD_SPARE0 + i))
            spare_q[i] <= wdata_i;
      end
   end

   assign start_o   = ctrl_wr && !busy_i && wdata_i[BIT_START];
   assign payload_o = {hi_q, wdata_i[LO_LSB +: BYTE_W]};
   assign lines_o   = lines_q;

   always_comb begin
      rdata_o = '0;
      if (idx == IDX_W'(WORD_CTRL))
         rdata_o = ctrl_word(lo_q, busy_i, lines_q);
      if (idx == IDX_W'(WORD_STAT))
         rdata_o[1:0] = stat_i;
      if (idx == IDX_W'(WORD_HI))
         rdata_o[BYTE_W-1:0] = hi_q;
      for (int i = 0; i < NUM_SPARE; i++)
         if (idx == IDX_W'(WORD_SPARE0 + i))
            rdata_o = spare_q[i];
   end
endmodule

// File: rtl/rtc_link_frontend.sv
module rtc_link_frontend
   import rtcfe_pkg::*;
#(
   parameter int          ADDR_W      = 5,
   parameter int          BUS_W       = 32,
   parameter int          NUM_SPARE   = 2,
   parameter int          SYNC_STAGES = 2,
   parameter int          HALF_CYC    = 2,
   parameter logic [15:0] CFG_RESET   = 16'h180A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic [3:0]        bus_byte_en,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              link_sclk,
   output logic              link_sen,
   output logic              link_sdi,
   input  logic              link_sdo,
   input  logic              link_rdy,
   output logic              cfg_clk,
   output logic              cfg_dat
);
   line_t             lines;
   logic              ser_busy;
   logic              ser_start;
   logic [CFG_W-1:0]  ser_payload;
   logic [1:0]        stat_sync;
   logic              unused_be;

   // every access is a full word
   assign unused_be = ^bus_byte_en;

   rtcfe_sync #(.STAGES(SYNC_STAGES), .W(2)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({link_rdy, link_sdo}),
      .q_o   (stat_sync)
   );

   rtcfe_regfile #(
      .ADDR_W    (ADDR_W),
      .BUS_W     (BUS_W),
      .NUM_SPARE (NUM_SPARE),
      .CFG_RESET (CFG_RESET)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (bus_wr_en),
      .addr_i    (bus_addr),
      .wdata_i   (bus_wdata),
      .busy_i    (ser_busy),
      .stat_i    (stat_sync),
      .lines_o   (lines),
      .start_o   (ser_start),
      .payload_o (ser_payload),
      .rdata_o   (bus_rdata)
   );

   rtcfe_cfg_shifter #(.HALF_CYC(HALF_CYC), .CFG_W(CFG_W)) i_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (ser_start),
      .payload_i (ser_payload),
      .busy_o    (ser_busy),
      .ser_clk_o (cfg_clk),
      .ser_dat_o (cfg_dat)
   );

   assign link_sclk = lines.sclk;
   assign link_sen  = lines.sen;
   assign link_sdi  = lines.sdi;
endmodule

// File: rtl/rtc_link_frontend_chk.sv
module rtc_link_frontend_chk #(
   parameter int ADDR_W   = 5,
   parameter int HALF_CYC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_en,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              link_sclk,
   input logic              link_sen,
   input logic              link_sdi,
   input logic              cfg_clk,
   input logic              cfg_dat,
   input logic              ser_busy
);
   localparam int SPAN = 32 * HALF_CYC;

   logic [ADDR_W-3:0] idx;
   logic              ctrl_wr;
   int                busy_span;

   assign idx     = bus_addr[ADDR_W-1:2];
   assign ctrl_wr = bus_wr_en && (idx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_span <= 0;
      else        busy_span <= ser_busy ? busy_span + 1 : 0;
   end

   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[17] && !ser_busy) |=> ser_busy);  // R5

   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_busy) |-> (busy_span == SPAN));  // R5

   AST_LINES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && ser_busy) |=> $stable({link_sdi, link_sen, link_sclk}));  // R7

   AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_busy |-> (!cfg_clk && !cfg_dat));  // R6

   AST_DAT_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_dat));  // R6

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (idx > 4) |-> (bus_rdata == 32'h0));  // R8
endmodule

bind rtc_link_frontend rtc_link_frontend_chk #(
   .ADDR_W   (ADDR_W),
   .HALF_CYC (HALF_CYC)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr_en (bus_wr_en),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .link_sclk (link_sclk),
   .link_sen  (link_sen),
   .link_sdi  (link_sdi),
   .cfg_clk   (cfg_clk),
   .cfg_dat   (cfg_dat),
   .ser_busy  (ser_busy)
);

// File: tb/test_rtc_link_frontend.sv
module test_rtc_link_frontend;
   localparam int H = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_byte_en = 4'hF;
   logic [31:0] bus_rdata;
   logic        link_sclk, link_sen, link_sdi;
   logic        link_sdo = 1'b0, link_rdy = 1'b0;
   logic        cfg_clk, cfg_dat;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   always #2 clk = ~clk;  // 250 MHz

   rtc_link_frontend i_rtc_link_frontend (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_byte_en(bus_byte_en), .bus_rdata(bus_rdata),
      .link_sclk(link_sclk), .link_sen(link_sen), .link_sdi(link_sdi),
      .link_sdo(link_sdo), .link_rdy(link_rdy), .cfg_clk(cfg_clk), .cfg_dat(cfg_dat)
   );

   // ---------------- behavioural reference model ----------------
   logic [2:0]  m_lines;
   logic [7:0]  m_lo, m_hi;
   logic [31:0] m_sp [2];
   logic        m_busy;
   int          m_cnt;
   logic [15:0] m_pay;
   logic [1:0]  m_s1, m_s2;

   always @(posedge clk) begin : model
      logic old_busy;
      int   widx;
      if (!rst_n) begin
         m_lines = 3'b000; m_lo = 8'h0A; m_hi = 8'h18;
         m_sp[0] = '0; m_sp[1] = '0;
         m_busy = 1'b0; m_cnt = 0; m_pay = '0;
         m_s1 = '0; m_s2 = '0;
      end else begin
         old_busy = m_busy;
         widx = int'(bus_addr) / 4;
         m_s2 = m_s1;
         m_s1 = {link_rdy, link_sdo};
         if (m_busy) begin
            m_cnt++;
            if (m_cnt == 32 * H) begin m_busy = 1'b0; m_cnt = 0; end
         end
         if (bus_wr_en) begin
            case (widx)
               0: begin
                  m_lo = bus_wdata[31:24];
                  if (!old_busy) begin
                     m_lines = bus_wdata[2:0];
                     if (bus_wdata[17]) begin
                        m_busy = 1'b1; m_cnt = 0; m_pay = {m_hi, bus_wdata[31:24]};
                     end
                  end
               end
               2: m_sp[0] = bus_wdata;
               3: m_sp[1] = bus_wdata;
               4: m_hi = bus_wdata[7:0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] m_read(input logic [4:0] a);
      logic [31:0] r;
      r = '0;
      case (int'(a) / 4)
         0: begin r[31:24] = m_lo; r[22] = m_busy; r[2:0] = m_lines; end
         1: r[1:0] = m_s2;
         2: r = m_sp[0];
         3: r = m_sp[1];
         4: r[7:0] = m_hi;
         default: ;
      endcase
      return r;
   endfunction

   function automatic string rd_tag(input logic [4:0] a);
      case (int'(a) / 4)
         0: return "R5";
         1: return "R3";
         2, 3, 4: return "R4";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison of every output against the model
   always @(posedge clk) begin : compare
      logic exp_clk, exp_dat;
      #1;
      if (!done) begin
         exp_clk = m_busy ? logic'((m_cnt / H) % 2) : 1'b0;
         exp_dat = m_busy ? m_pay[15 - m_cnt / (2 * H)] : 1'b0;
         chk("R2", {29'b0, link_sdi, link_sen, link_sclk}, {29'b0, m_lines});
         chk("R6", {30'b0, cfg_clk, cfg_dat}, {30'b0, exp_clk, exp_dat});
         chk(rd_tag(bus_addr), bus_rdata, m_read(bus_addr));
      end
   end

   // independent capture of the shifted word on rising cfg_clk
   logic [15:0] cap = '0;
   int          ncap = 0;
   logic        prev_clk = 1'b0;
   always @(posedge clk) begin
      #1;
      if (cfg_clk && !prev_clk) begin cap = {cap[14:0], cfg_dat}; ncap++; end
      prev_clk = cfg_clk;
   end

   // ---------------- stimulus ----------------
   task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d; bus_byte_en = be;
      @(negedge clk);
      bus_wr_en = 1'b0; bus_byte_en = 4'hF;
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      // R1: reset state
      rd_chk("R1", 5'h00, 32'h0A00_0000);
      rd_chk("R1", 5'h10, 32'h0000_0018);
      rd_chk("R1", 5'h08, 32'h0);
      chk("R1", {30'b0, cfg_clk, cfg_dat}, 32'h0);

      // R1 + R6: shift out the reset configuration 0x180A
      cap = '0; ncap = 0;
      wr(5'h00, 32'h0A02_0000);
      idle(32 * H + 4);
      chk("R6", {16'h0, cap}, 32'h0000_180A);
      chk("R6", ncap, 16);

      // R2: manual link wires
      wr(5'h00, 32'h0A00_0005);
      #1 chk("R2", {29'b0, link_sdi, link_sen, link_sclk}, 32'h5);
      wr(5'h00, 32'h0A00_0002);
      rd_chk("R2", 5'h00, 32'h0A00_0002);

      // R3: status through the synchronizer
      bus_addr = 5'h04;
      @(negedge clk); link_sdo = 1'b1; link_rdy = 1'b0;
      idle(3);
      rd_chk("R3", 5'h04, 32'h1);
      @(negedge clk); link_sdo = 1'b0; link_rdy = 1'b1;
      idle(3);
      rd_chk("R3", 5'h04, 32'h2);

      // R4: spare words and upper byte
      wr(5'h08, 32'hDEAD_BEEF);
      wr(5'h0C, 32'h1234_5678);
      wr(5'h10, 32'hFFFF_FFA5);
      rd_chk("R4", 5'h08, 32'hDEAD_BEEF);
      rd_chk("R4", 5'h0C, 32'h1234_5678);
      rd_chk("R4", 5'h10, 32'h0000_00A5);

      // R9: byte enables ignored
      wr(5'h08, 32'h0BAD_F00D, 4'h0);
      rd_chk("R9", 5'h08, 32'h0BAD_F00D);

      // R8: unmapped and read-only offsets
      wr(5'h14, 32'hFFFF_FFFF);
      wr(5'h04, 32'hFFFF_FFFF);
      rd_chk("R8", 5'h14, 32'h0);
      rd_chk("R8", 5'h1C, 32'h0);
      rd_chk("R8", 5'h04, 32'h2);
      rd_chk("R8", 5'h10, 32'h0000_00A5);

      // R5 + R7: launch 0xA53C, then disturb it while busy
      cap = '0; ncap = 0;
      wr(5'h00, 32'h3C02_0002);
      rd_chk("R5", 5'h00, 32'h3C40_0002);
      wr(5'h00, 32'hFF02_0007);
      #1 chk("R7", {29'b0, link_sdi, link_sen, link_sclk}, 32'h2);
      wr(5'h10, 32'h0000_0077);
      rd_chk("R7", 5'h00, 32'hFF40_0002);
      idle(32 * H);
      rd_chk("R5", 5'h00, 32'hFF00_0002);
      chk("R7", {16'h0, cap}, 32'h0000_A53C);
      chk("R6", ncap, 16);

      // R5: a new start after completion uses the new upper byte
      cap = '0; ncap = 0;
      wr(5'h00, 32'h8102_0000);
      idle(32 * H + 4);
      chk("R5", {16'h0, cap}, 32'h0000_7781);

      idle(2);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule